// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block sits between five interrupt sources and a processor core. The sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. It masks each source through an enable register that also holds a master switch. Each source is assigned one of four priority levels by a pair of bits, one in a high-priority register and one in a low-priority register. Among the unmasked pending sources it picks one winner. It raises a vector request with the winner's index only when the winner can legally preempt whatever handler is running.

The core answers a request with a one-cycle acknowledge, which marks the granted level as in service. When a handler finishes, the core pulses the return strobe, which retires the highest level in service. A small register port writes and reads the three configuration registers.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, all three registers read 0, no request is raised, and no level is in service, so any unmasked source at any level can raise a request.
- R2: The enable register holds the master enable at bit 7 and the per-source enables at bits 4..0. Bit 0 is external 0, bit 1 is timer 0, bit 2 is external 1, bit 3 is timer 1 and bit 4 is serial. Bits 6 and 5 always read 0.
- R3: While the master enable is 0, no source raises a request. While it is 1, a source is eligible only if its own enable bit is 1 and its request line is high.
- R4: A source's level is {high-priority bit, low-priority bit}, from 0 (lowest) to 3 (highest). Among eligible sources, one at the highest level wins.
- R5: Among eligible sources at the same level, the lowest source index wins. The order is external 0 (index 0), then timer 0, external 1, timer 1 and serial (index 4).
- R6: A request is raised only when no level is in service, or when the winner's level is strictly greater than the highest level in service. As a result, nothing preempts a level-3 handler.
- R7: Once raised, the request and its 3-bit index hold unchanged until acknowledge, even if the sources or the registers change.
- R8: An acknowledge while a request is up drops the request on the next cycle and marks the granted level as in service. A return strobe clears only the highest in-service level, which lets a waiting lower-level request through.
- R9: The register select picks the register: 0 is enable, 1 is the low-priority register and 2 is the high-priority register. Each priority register uses bits 4..0 in source order, and its bits 7..5 read 0. Select 3 reads 0. A write takes effect at the clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | 5 | Pending request lines, bit i for source index i |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| irq_req | output | 1 | Vector request to the core |
| irq_idx | output | 3 | Index of the requested source |
| irq_ack | input | 1 | Core acknowledge of the request |
| irq_ret | input | 1 | Return-from-handler strobe |

## Verification
The bench builds the block with its defaults: five sources and four levels. At this size, every mix of levels, enables and pending lines is reachable by random stimulus, and so is every in-service pattern, from empty to all four levels stacked. Directed sequences stack levels 0, 1 and 3. They then show that a level-2 request is blocked until the level-3 handler returns, and that a level-0 request waits until the last return.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC = 5,
  parameter int NLVL = 4,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq_req,
  output logic [IW-1:0]   irq_idx,
  input  logic            irq_ack,
  input  logic            irq_ret
);
  logic            en_all;
  logic [NSRC-1:0] en_src, plo, phi, elig;
  logic [NLVL-1:0] isr, isr_nx;
  logic [1:0]      req_lvl, win_lvl, top_lvl;
  logic [IW-1:0]   win_idx;
  logic            win_vld, allow;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata[6:5];
  assign elig = src_req & en_src & {NSRC{en_all}};

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i] && (!win_vld || {phi[i], plo[i]} > win_lvl)) begin
        win_vld = 1'b1;
        win_idx = i[IW-1:0];
        win_lvl = {phi[i], plo[i]};
      end
  end

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (isr[l]) top_lvl = l[1:0];
  end

  assign allow = (isr == '0) || (win_lvl > top_lvl);

  always_comb begin
    isr_nx = isr;
    if (irq_ret && isr != '0) isr_nx[top_lvl] = 1'b0;
    if (irq_req && irq_ack) isr_nx[req_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_all <= 1'b0;
      en_src <= '0;
      plo    <= '0;
      phi    <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: begin en_all <= reg_wdata[7]; en_src <= reg_wdata[NSRC-1:0]; end
        2'd1: plo <= reg_wdata[NSRC-1:0];
        2'd2: phi <= reg_wdata[NSRC-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_idx <= '0;
      req_lvl <= '0;
      isr     <= '0;
    end else begin
      isr <= isr_nx;
      if (irq_req) begin
        if (irq_ack) irq_req <= 1'b0;
      end else if (win_vld && allow) begin
        irq_req <= 1'b1;
        irq_idx <= win_idx;
        req_lvl <= win_lvl;
      end
    end

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = {en_all, {(7-NSRC){1'b0}}, en_src};
      2'd1:    reg_rdata = {{(8-NSRC){1'b0}}, plo};
      2'd2:    reg_rdata = {{(8-NSRC){1'b0}}, phi};
      default: reg_rdata = 8'h00;
    endcase
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic [2:0] irq_idx,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       gen,
  input logic [3:0] isr,
  input logic [1:0] req_lvl
);
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_idx));

  a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen && !irq_req |=> !irq_req);

  a_r6_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    isr[3] && !irq_req |=> !irq_req);

  a_r6_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (($past(isr) >> req_lvl) == 4'd0));

  a_r8_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req && isr != 4'd0);

  a_r8_ret_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret && !(irq_req && irq_ack) && isr != 4'd0 |=>
      $countones(isr) == $countones($past(isr)) - 1);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_idx(irq_idx),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .gen(en_all), .isr(isr),
  .req_lvl(req_lvl)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic [4:0] src_req = 0;
  logic       reg_we = 0, irq_ack = 0, irq_ret = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq_req;
  logic [2:0] irq_idx;
  int n_chk = 0, n_bad = 0;
  logic [3:0] misr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl u_dut (.clk, .rst_n, .src_req, .reg_we, .reg_sel, .reg_wdata,
    .reg_rdata, .irq_req, .irq_idx, .irq_ack, .irq_ret);

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic settle(logic [4:0] s);
    @(negedge clk); src_req = s;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic ack(logic [1:0] lvl);
    @(negedge clk); irq_ack = 1; src_req = 0;
    @(negedge clk); irq_ack = 0;
    misr[lvl] = 1'b1;
  endtask

  function automatic logic [1:0] top(logic [3:0] v);
    for (int l = 3; l >= 0; l--) if (v[l]) return l[1:0];
    return 2'd0;
  endfunction

  task automatic ret();
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
    if (misr != 0) misr[top(misr)] = 1'b0;
  endtask

  function automatic logic [5:0] pick(logic [4:0] s, logic [7:0] e,
                                      logic [4:0] l, logic [4:0] h);
    for (int lv = 3; lv >= 0; lv--)
      for (int i = 0; i < 5; i++)
        if (e[7] && e[i] && s[i] && {h[i], l[i]} == lv[1:0])
          return {1'b1, i[2:0], lv[1:0]};
    return 6'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e, l, h;
    logic [4:0] s;
    logic [5:0] p;
    logic exp_req;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 req", irq_req, 0);
    for (int k = 0; k < 3; k++) begin rd(k[1:0], d); chk("R1 reg", d, 0); end
    // R2 / R9 register port
    wr(0, 8'hFF); rd(0, d); chk("R2 enable layout", d, 8'h9F);
    wr(1, 8'hFF); rd(1, d); chk("R9 low prio", d, 8'h1F);
    wr(2, 8'h15); rd(2, d); chk("R9 high prio", d, 8'h15);
    rd(3, d); chk("R9 sel3", d, 0);
    wr(1, 0); wr(2, 0);
    // R3 master off
    wr(0, 8'h1F); settle(5'h1F); chk("R3 masked", irq_req, 0);
    // R5 polling with all at level 0
    wr(0, 8'h9F); @(negedge clk); @(negedge clk);
    chk("R5 req", irq_req, 1); chk("R5 idx", irq_idx, 0);
    // R7 hold while inputs change
    src_req = 0; wr(0, 8'h00); @(negedge clk); @(negedge clk);
    chk("R7 req held", irq_req, 1); chk("R7 idx held", irq_idx, 0);
    ack(0); chk("R8 req drop", irq_req, 0);
    wr(0, 8'h9F);
    // R6 same level waits
    settle(5'h10); chk("R6 same level", irq_req, 0);
    wr(1, 8'h02); settle(5'h02); chk("R6 higher req", irq_req, 1);
    chk("R6 idx", irq_idx, 1); ack(1);
    wr(2, 8'h10); wr(1, 8'h12); settle(5'h10);
    chk("R4 level3 idx", irq_idx, 4); ack(3);
    wr(2, 8'h14); settle(5'h04); chk("R6 level3 blocks", irq_req, 0);
    ret(); @(negedge clk); chk("R8 after ret", irq_req, 1);
    chk("R8 idx", irq_idx, 2); ack(2);
    settle(5'h01); ret(); @(negedge clk); chk("R8 still nested", irq_req, 0);
    ret(); @(negedge clk); chk("R8 still nested 2", irq_req, 0);
    ret(); @(negedge clk); chk("R8 last ret", irq_req, 1);
    chk("R8 low idx", irq_idx, 0); ack(0); ret();
    // R4 highest level wins over poll order
    wr(2, 0); wr(1, 8'h08); settle(5'h0F);
    chk("R4 req", irq_req, 1); chk("R4 idx", irq_idx, 3); ack(1); ret();
    // random
    for (int it = 0; it < 400; it++) begin
      e = 8'($urandom) & 8'h9F; if ($urandom % 5 != 0) e[7] = 1;
      l = 8'($urandom) & 8'h1F; h = 8'($urandom) & 8'h1F;
      wr(0, e); wr(1, l); wr(2, h);
      s = 5'($urandom);
      settle(s);
      p = pick(s, e, l[4:0], h[4:0]);
      exp_req = p[5] && (misr == 0 || p[1:0] > top(misr));
      chk("R3 R4 R6 rand req", irq_req, exp_req);
      if (exp_req) chk("R4 R5 rand idx", irq_idx, p[4:2]);
      if (irq_req) ack(p[1:0]);
      else begin @(negedge clk); src_req = 0; end
      if ($urandom % 3 == 0 || misr == 4'hF) ret();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule